// File: doc/BRIEF.md
# Four-Channel Direct Digital Synthesis Core

This block turns per-channel frequency, phase and amplitude settings into four streams of DAC codes, one new code per channel on every cycle of a single shared clock. Every channel advances a 32-bit phase register by its frequency tuning word on each cycle. The top 14 bits of that register, plus a 14-bit phase offset, form the phase. A quarter-wave cosine table turns the phase into a signed amplitude, and a 10-bit scale factor multiplies that amplitude into a 10-bit offset-binary code. All channels run from one clock, so their phases stay locked to each other.

The settings come straight from the active registers of the surrounding logic. A mode input chooses how fast the three settings take effect. In the default mode each setting has its own latency. In matched mode, delay stages are added on the faster paths, so a frequency, phase and amplitude change written together reaches the output on the same cycle. Matched mode is meant for single-tone use.

Top module: `quad_dds_core`

## Requirements
- R1: The four channels share one clock. The output of each channel depends only on that channel's own slices of the three input buses. Channel c uses bits [c*32 +: 32], [c*14 +: 14], [c*10 +: 10] and [c*10 +: 10] of the four buses.
- R2: On every clock edge with reset low, each channel adds its tuning word to its 32-bit phase register, modulo 2^32. The upper 14 bits of the register are the phase, so the output frequency is FTW × fclk / 2^32.
- R3: Tuning words are legal only below 2^31 (bit 31 clear). The largest legal word, 0x7FFF_FFFF, is handled like any other value.
- R4: A tuning word of 0 freezes the phase register. With the offset and scale also held, the output code does not change from cycle to cycle.
- R5: The phase offset is added modulo 2^14 to the upper 14 phase-register bits, so one offset step is 360°/2^14. Bits [13:4] of the sum, p, select the signed amplitude C = round(511·cos(2π(p+0.5)/1024)). C comes from a 256-entry quarter-wave table: quadrants 1 and 2 are negative, and quadrants 1 and 3 read the table mirrored.
- R6: The output code is 512 + floor(C·A/1024), where A is the unsigned 10-bit scale. The code therefore lies between 1 and 1022. A scale of 0 gives 512.
- R7: With matched mode off, a tuning-word change first shows on the output 4 clock edges after it is sampled. A phase-offset change takes 3 edges and a scale change takes 1 edge. The edge that samples the change counts as the first.
- R8: With matched mode on, all three settings take 4 edges. Mode changes act at once on the selection, and the delay stages keep running in both modes.
- R9: A synchronous reset clears every phase register and pipeline stage. The edge that samples reset drives every output to 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared system clock |
| rst | input | 1 | Synchronous reset, active high |
| matchEn | input | 1 | 1 = equal latency for all three settings |
| ftwBus | input | NUM_CH×32 (128) | Frequency tuning words, channel 0 in the low bits |
| powBus | input | NUM_CH×14 (56) | Phase offset words |
| ampBus | input | NUM_CH×10 (40) | Amplitude scale factors |
| sampleBus | output | NUM_CH×10 (40) | Offset-binary DAC codes |

## Verification
A phase-offset update and a scale update can land on the same output cycle. In the default mode this happens when the offset is written two cycles before the scale. In matched mode it happens when both are written together, possibly while the mode itself flips. The bench changes all three settings of each channel at random, cycle by cycle, under both modes and across mode toggles. It keeps its own record of phase sums and input history and predicts each output code from the stated latencies and the cosine formula. Any mismatch in which setting took effect on which edge shows up as a wrong code.

// File: rtl/quad_dds_pkg.sv
package quad_dds_pkg;

  // Latency in clock edges from sampled input to output register.
  localparam int FTW_LAT = 4;
  localparam int POW_LAT = 3;
  localparam int AMP_LAT = 1;

  // pi scaled by 2^30, for elaboration-time table construction
  localparam longint PI_Q30 = 64'sd3373259426;

  typedef struct packed {
    logic clear;    // synchronous clear of all state
    logic matched;  // equal-latency selection
    logic primed;   // previous edge was not a reset edge
  } dds_ctl_t;

endpackage

// File: rtl/dds_ctrl.sv
module dds_ctrl
  import quad_dds_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     matchEn,
  output dds_ctl_t ctl
);

  logic primedQ;

  always_ff @(posedge clk) begin
    primedQ <= !rst;
  end

  assign ctl.clear   = rst;
  assign ctl.matched = matchEn;
  assign ctl.primed  = primedQ;

endmodule

// File: rtl/dds_channel.sv
module dds_channel
  import quad_dds_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 14,
  parameter int AMP_W   = 10,
  parameter int OUT_W   = 10,
  parameter int LUT_AW  = 8
) (
  input  logic               clk,
  input  dds_ctl_t           ctl,
  input  logic [ACC_W-1:0]   ftw,
  input  logic [PHASE_W-1:0] pow,
  input  logic [AMP_W-1:0]   amp,
  output logic [OUT_W-1:0]   sample
);

  localparam int MAG_W    = OUT_W - 1;
  localparam int QTR_N    = 1 << LUT_AW;
  localparam int ROM_BITS = QTR_N * MAG_W;
  localparam int MAX_MAG  = (1 << MAG_W) - 1;
  localparam int LSB_DROP = PHASE_W - 2 - LUT_AW;
  localparam int POW_XTRA = FTW_LAT - POW_LAT;
  localparam int AMP_XTRA = FTW_LAT - AMP_LAT;
  localparam int PROD_W   = OUT_W + AMP_W + 1;
  localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W - 1));

  // Quarter-wave cosine magnitudes sampled at half-step offsets,
  // evaluated by fixed-point Taylor series at elaboration.
  function automatic logic [ROM_BITS-1:0] buildRom();
    logic [ROM_BITS-1:0] rom;
    longint th, th2, term, sum, mag;
    rom = '0;
    for (int i = 0; i < QTR_N; i++) begin
      th   = (longint'(2 * i + 1) * PI_Q30) / longint'(4 * QTR_N);
      th2  = (th * th) >>> 30;
      term = 64'sd1 <<< 30;
      sum  = term;
      for (int k = 1; k <= 7; k++) begin
        term = -(((term * th2) >>> 30) / longint'((2 * k - 1) * (2 * k)));
        sum  = sum + term;
      end
      mag = (longint'(MAX_MAG) * sum + (64'sd1 <<< 29)) >>> 30;
      if (mag < 0) mag = 0;
      if (mag > MAX_MAG) mag = MAX_MAG;
      rom[i*MAG_W +: MAG_W] = MAG_W'(mag);
    end
    return rom;
  endfunction

  localparam logic [ROM_BITS-1:0] COS_ROM = buildRom();

  logic [ACC_W-1:0]   acc;
  logic [PHASE_W-1:0] powDly [POW_XTRA];
  logic [AMP_W-1:0]   ampDly [AMP_XTRA];
  logic [PHASE_W-1:0] powSel;
  logic [AMP_W-1:0]   ampSel;
  logic [PHASE_W-1:0] phReg;
  logic signed [OUT_W-1:0] cosQ;

  assign powSel = ctl.matched ? powDly[POW_XTRA-1] : pow;
  assign ampSel = ctl.matched ? ampDly[AMP_XTRA-1] : amp;

  // Stage 1: accumulate, and run the equalising delay lines
  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      acc <= '0;
      for (int i = 0; i < POW_XTRA; i++) powDly[i] <= '0;
      for (int i = 0; i < AMP_XTRA; i++) ampDly[i] <= '0;
    end else begin
      acc       <= acc + ftw;
      powDly[0] <= pow;
      for (int i = 1; i < POW_XTRA; i++) powDly[i] <= powDly[i-1];
      ampDly[0] <= amp;
      for (int i = 1; i < AMP_XTRA; i++) ampDly[i] <= ampDly[i-1];
    end
  end

  // Stage 2: phase offset
  always_ff @(posedge clk) begin
    if (ctl.clear) phReg <= '0;
    else           phReg <= acc[ACC_W-1 -: PHASE_W] + powSel;
  end

  // Stage 3: quarter-wave lookup with quadrant folding
  logic [1:0]        quad;
  logic [LUT_AW-1:0] idx;
  logic [LUT_AW-1:0] addr;
  logic [MAG_W-1:0]  mag;
  logic              negHalf;

  assign quad    = phReg[PHASE_W-1 -: 2];
  assign idx     = phReg[PHASE_W-3 -: LUT_AW];
  assign addr    = quad[0] ? ~idx : idx;
  assign mag     = COS_ROM[addr*MAG_W +: MAG_W];
  assign negHalf = quad[1] ^ quad[0];

  generate
    if (LSB_DROP > 0) begin : g_lsb
      logic unusedPhaseLsb;
      assign unusedPhaseLsb = ^phReg[LSB_DROP-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (ctl.clear)    cosQ <= '0;
    else if (negHalf) cosQ <= -$signed({1'b0, mag});
    else              cosQ <= $signed({1'b0, mag});
  end

  // Stage 4: amplitude scale, offset-binary output
  logic signed [PROD_W-1:0] prod;
  logic [OUT_W-1:0]         scaled;
  logic                     unusedProdBits;

  assign prod   = PROD_W'(cosQ) * PROD_W'($signed({1'b0, ampSel}));
  assign scaled = prod[AMP_W +: OUT_W];
  assign unusedProdBits = ^{prod[PROD_W-1], prod[AMP_W-1:0]};

  always_ff @(posedge clk) begin
    if (ctl.clear) sample <= MID;
    else           sample <= {~scaled[OUT_W-1], scaled[OUT_W-2:0]};
  end

  // R3: tuning word range
  a_r3_ftw_range: assert property (@(posedge clk) disable iff (ctl.clear)
    ftw[ACC_W-1] == 1'b0);

  // R4: zero step freezes the phase register
  a_r4_zero_hold: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl.primed && $past(ftw) == '0) |-> (acc == $past(acc)));

  // R5: negative half-cycle quadrants yield negative amplitude
  a_r5_quad_sign: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl.primed && ($past(phReg[PHASE_W-1 -: 2]) == 2'd1 ||
                    $past(phReg[PHASE_W-1 -: 2]) == 2'd2)) |-> cosQ[OUT_W-1]);

  // R6: code never reaches zero
  a_r6_code_floor: assert property (@(posedge clk) disable iff (ctl.clear)
    ctl.primed |-> (sample != '0));

  // R7: zero scale on the one-edge path gives midscale
  a_r7_amp_zero_mid: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl.primed && !$past(ctl.matched) && $past(amp) == '0) |-> (sample == MID));

endmodule

// File: rtl/dds_datapath.sv
module dds_datapath
  import quad_dds_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 14,
  parameter int AMP_W   = 10,
  parameter int OUT_W   = 10,
  parameter int LUT_AW  = 8
) (
  input  logic                      clk,
  input  dds_ctl_t                  ctl,
  input  logic [NUM_CH*ACC_W-1:0]   ftwBus,
  input  logic [NUM_CH*PHASE_W-1:0] powBus,
  input  logic [NUM_CH*AMP_W-1:0]   ampBus,
  output logic [NUM_CH*OUT_W-1:0]   sampleBus
);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dds_channel #(
        .ACC_W(ACC_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W),
        .OUT_W(OUT_W), .LUT_AW(LUT_AW)
      ) u_ch (
        .clk    (clk),
        .ctl    (ctl),
        .ftw    (ftwBus[c*ACC_W +: ACC_W]),
        .pow    (powBus[c*PHASE_W +: PHASE_W]),
        .amp    (ampBus[c*AMP_W +: AMP_W]),
        .sample (sampleBus[c*OUT_W +: OUT_W])
      );
    end
  endgenerate

endmodule

// File: rtl/quad_dds_core.sv
module quad_dds_core
  import quad_dds_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 14,
  parameter int AMP_W   = 10,
  parameter int OUT_W   = 10,
  parameter int LUT_AW  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      matchEn,
  input  logic [NUM_CH*ACC_W-1:0]   ftwBus,
  input  logic [NUM_CH*PHASE_W-1:0] powBus,
  input  logic [NUM_CH*AMP_W-1:0]   ampBus,
  output logic [NUM_CH*OUT_W-1:0]   sampleBus
);

  dds_ctl_t ctl;

  dds_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .matchEn (matchEn),
    .ctl     (ctl)
  );

  dds_datapath #(
    .NUM_CH(NUM_CH), .ACC_W(ACC_W), .PHASE_W(PHASE_W),
    .AMP_W(AMP_W), .OUT_W(OUT_W), .LUT_AW(LUT_AW)
  ) u_dp (
    .clk       (clk),
    .ctl       (ctl),
    .ftwBus    (ftwBus),
    .powBus    (powBus),
    .ampBus    (ampBus),
    .sampleBus (sampleBus)
  );

endmodule

// File: tb/quad_dds_core_test.sv
module quad_dds_core_test;

  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic matchEn = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] ftwV [NCH];
  logic [13:0] powV [NCH];
  logic [9:0]  ampV [NCH];
  logic [NCH*32-1:0] ftwBus;
  logic [NCH*14-1:0] powBus;
  logic [NCH*10-1:0] ampBus;
  logic [NCH*10-1:0] sampleBus;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ftwBus[c*32 +: 32] = ftwV[c];
      powBus[c*14 +: 14] = powV[c];
      ampBus[c*10 +: 10] = ampV[c];
    end
  end

  quad_dds_core uut (
    .clk(clk), .rst(rst), .matchEn(matchEn),
    .ftwBus(ftwBus), .powBus(powBus), .ampBus(ampBus),
    .sampleBus(sampleBus)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int k = 0;

  // Reference history, ring of 8 edges
  logic [31:0] hAcc [NCH][8];
  logic [13:0] hPow [NCH][8];
  logic [9:0]  hAmp [NCH][8];
  logic [13:0] hPs  [NCH][8];
  logic        hM   [8];

  function automatic int cosRef(int p);
    real ang;
    ang = 2.0 * 3.14159265358979 * (real'(p) + 0.5) / 1024.0;
    return int'(511.0 * $cos(ang));
  endfunction

  function automatic int codeRef(int cv, int a);
    int prodV;
    prodV = cv * a;
    return 512 + (prodV >>> 10);
  endfunction

  function automatic int outOf(int c);
    return int'(sampleBus[c*10 +: 10]);
  endfunction

  task automatic check(int c, int act, int exp, string req, int tol);
    int d;
    total++;
    d = act - exp;
    if (d < -tol || d > tol) begin
      bad++;
      $display("FAIL %s ch%0d: actual=%0d expected=%0d", req, c, act, exp);
    end
  endtask

  task automatic step(string req);
    int prev, slot, a;
    logic [13:0] pv;
    @(posedge clk);
    prev = k & 7;
    k++;
    slot = k & 7;
    hM[slot] = matchEn;
    for (int c = 0; c < NCH; c++) begin
      hAcc[c][slot] = hAcc[c][prev] + ftwV[c];
      pv = matchEn ? hPow[c][prev] : powV[c];
      hPs[c][slot]  = hAcc[c][prev][31:18] + pv;
      hPow[c][slot] = powV[c];
      hAmp[c][slot] = ampV[c];
    end
    @(negedge clk);
    if (k >= 4) begin
      for (int c = 0; c < NCH; c++) begin
        a = hM[slot] ? int'(hAmp[c][(k-3) & 7]) : int'(hAmp[c][slot]);
        check(c, outOf(c), codeRef(cosRef(int'(hPs[c][(k-2) & 7][13:4])), a), req, 1);
      end
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk);
    k = 0;
    hM[0] = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      hAcc[c][0] = '0; hPow[c][0] = '0; hAmp[c][0] = '0; hPs[c][0] = '0;
    end
    @(negedge clk);
    for (int c = 0; c < NCH; c++) check(c, outOf(c), 512, "R9", 0);
    rst = 1'b0;
  endtask

  function automatic logic [31:0] rndFtw();
    return $urandom & 32'h7FFF_FFFF;
  endfunction

  task automatic randomise(int c, int oneIn);
    if ($urandom % oneIn == 0) ftwV[c] = rndFtw();
    if ($urandom % oneIn == 0) powV[c] = 14'($urandom);
    if ($urandom % oneIn == 0) ampV[c] = 10'($urandom);
  endtask

  initial begin
    int held [NCH];
    for (int c = 0; c < NCH; c++) begin
      ftwV[c] = '0; powV[c] = '0; ampV[c] = '0;
    end
    @(negedge clk);
    doReset();

    // R2: steady distinct tones per channel
    for (int c = 0; c < NCH; c++) begin
      ftwV[c] = (32'h0123_4567 * (c + 1)) & 32'h7FFF_FFFF;
      powV[c] = 14'(c * 1000);
      ampV[c] = 10'(1023 - c * 200);
    end
    repeat (300) step("R2");

    // R5: offset sweep over every table position, frozen phase
    for (int c = 0; c < NCH; c++) begin ftwV[c] = '0; ampV[c] = 10'd1023; end
    for (int j = 0; j < 1024; j++) begin
      for (int c = 0; c < NCH; c++) powV[c] = 14'(j * 16 + c * 4096 + c);
      step("R5");
    end

    // R4: zero tuning word keeps the output constant
    for (int c = 0; c < NCH; c++) begin
      ftwV[c] = '0; powV[c] = 14'($urandom); ampV[c] = 10'($urandom);
    end
    repeat (6) step("R4");
    repeat (40) begin
      for (int c = 0; c < NCH; c++) held[c] = outOf(c);
      step("R4");
      for (int c = 0; c < NCH; c++) check(c, outOf(c), held[c], "R4", 0);
    end

    // R6: extreme scales and code range
    for (int n = 0; n < 200; n++) begin
      for (int c = 0; c < NCH; c++) begin
        ftwV[c] = rndFtw();
        ampV[c] = (n % 3 == 0) ? 10'd0 : 10'd1023;
      end
      step("R6");
      for (int c = 0; c < NCH; c++)
        if (k >= 4) begin
          total++;
          if (outOf(c) < 1 || outOf(c) > 1022) begin
            bad++;
            $display("FAIL R6 ch%0d: actual=%0d expected=1..1022", c, outOf(c));
          end
        end
    end

    // R7: default latencies under random per-cycle changes
    matchEn = 1'b0;
    repeat (400) begin
      for (int c = 0; c < NCH; c++) randomise(c, 3);
      step("R7");
    end

    // R8: matched latency, then mode toggling
    matchEn = 1'b1;
    repeat (400) begin
      for (int c = 0; c < NCH; c++) randomise(c, 3);
      step("R8");
    end
    repeat (300) begin
      matchEn = $urandom % 2 == 0;
      for (int c = 0; c < NCH; c++) randomise(c, 2);
      step("R8");
    end
    matchEn = 1'b0;

    // R3: largest legal tuning word
    ftwV[0] = 32'h7FFF_FFFF;
    ftwV[1] = 32'h7FFF_FFFF;
    repeat (200) step("R3");

    // R1: only channel 2 moves
    repeat (200) begin
      randomise(2, 1);
      step("R1");
    end

    // R9: mid-run reset clears phase
    for (int c = 0; c < NCH; c++) begin
      ftwV[c] = '0; powV[c] = '0; ampV[c] = 10'd1023;
    end
    doReset();
    repeat (6) step("R9");
    for (int c = 0; c < NCH; c++) check(c, outOf(c), 1022, "R9", 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule